// File: doc/BRIEF.md
# Averaging-Memory Priority Arbiter with Busy Retry

This block lets two clients share one single-port synchronous memory of complex samples. The first client is the real-time averaging engine. It reads a stored point, combines it with a fresh sample, and writes the result back. The second client is a host read port that fetches stored points for software. The averaging engine always wins: its requests are granted in the cycle they are raised.

A host read is refused with a one-cycle busy flag in two cases: when it collides with an averaging access, or when it arrives while an averaging read-modify-write pair is still open. The host is expected to issue the refused read again. An accepted host read returns its point with a valid pulse two clocks later.

Each stored point is 64 bits wide, holding a 32-bit real part and a 32-bit imaginary part. The address width is a parameter: 9 bits for a 512-point memory, or 18 bits for a 262144-point memory.

Top module: `avm_arbiter`

## Requirements
- R1: An averager request is granted in the same cycle (`av_gnt` equals `av_req`), whatever the host does.
- R2: A host request raised in a cycle with an averager request gets `hs_busy` high in that cycle and is not served.
- R3: A granted averager read (`av_we`=0) opens a pair, and a granted averager write (`av_we`=1) closes it. While a pair is open, every host request is answered busy, even in cycles without an averager request.
- R4: `hs_busy` is high only in a cycle where `hs_req` is high, so busy lasts exactly the refused request cycle.
- R5: A host request that is not busy is accepted. Exactly two clocks later, `hs_valid` pulses for one cycle and `hs_rdata` carries the point stored at the requested address. Back-to-back accepted reads return back-to-back.
- R6: A refused host request produces no `hs_valid` pulse.
- R7: A granted averager read sets `av_rvalid` one clock later, with `av_rdata` holding the point stored at the read address before that cycle.
- R8: A granted averager write stores `av_wdata` at `av_addr`, and later reads from either client return it. The real part sits in bits [63:32] and the imaginary part in bits [31:0].
- R9: After reset, `hs_valid` and `av_rvalid` are low and no pair is open, so a host request in the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| av_req | input | 1 | Averager access request |
| av_we | input | 1 | Averager access is a write (1) or read (0) |
| av_addr | input | ADDR_W | Averager point address |
| av_wdata | input | 64 | Averager write point {real, imag} |
| av_gnt | output | 1 | Averager grant |
| av_rvalid | output | 1 | Averager read data valid |
| av_rdata | output | 64 | Averager read point {real, imag} |
| hs_req | input | 1 | Host read request |
| hs_addr | input | ADDR_W | Host read address |
| hs_busy | output | 1 | Host request refused, retry |
| hs_valid | output | 1 | Host read data valid |
| hs_rdata | output | 64 | Host read point {real, imag} |

## Verification
The bench first fills part of the memory using averager writes whose real and imaginary halves differ. It then reads those points back with host reads spaced out, back to back, and at the lowest and highest addresses. These tell apart wrong return latency, wrong address and swapped halves.

Directed collisions follow. One puts a host request in the same cycle as an averager write, and one puts it in the idle gap inside an averager read-modify-write pair. The first exposes a wrong priority and the second a pair lock that is missing.

A long pseudo-random mix of averager read/write pairs with host requests ends the run. A behavioural model compares every clock against it, which catches busy flags that last too long and return pulses that are lost or spurious.

// File: rtl/avm_pkg.sv
package avm_pkg;
    localparam int PART_W  = 32;
    localparam int POINT_W = 2 * PART_W;

    typedef struct packed {
        logic [PART_W-1:0] re;
        logic [PART_W-1:0] im;
    } cpoint_t;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_AVG   = 2'd1,
        OWN_HOST  = 2'd2
    } owner_e;

    function automatic owner_e pick_owner(input logic avg_req, input logic host_ok);
        if (avg_req)      return OWN_AVG;
        else if (host_ok) return OWN_HOST;
        else              return OWN_NONE;
    endfunction
endpackage

// File: rtl/avm_ram.sv
module avm_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) store[addr] <= wdata;
            else    rdata       <= store[addr];
        end
    end
endmodule

// File: rtl/avm_arb.sv
module avm_arb
    import avm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              av_req,
    input  logic              av_we,
    input  logic [ADDR_W-1:0] av_addr,
    input  logic              hs_req,
    input  logic [ADDR_W-1:0] hs_addr,
    output logic              av_gnt,
    output logic              hs_busy,
    output logic              hs_acc,
    output logic              av_rd_go,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr
);
    logic   pair_open_q;
    owner_e owner;

    always_comb begin
        av_gnt   = av_req;
        hs_busy  = hs_req & (av_req | pair_open_q);
        hs_acc   = hs_req & ~hs_busy;
        owner    = pick_owner(av_req, hs_acc);
        av_rd_go = (owner == OWN_AVG) & ~av_we;
        ram_en   = (owner != OWN_NONE);
        ram_we   = (owner == OWN_AVG) & av_we;
        ram_addr = (owner == OWN_AVG) ? av_addr : hs_addr;
    end

    always_ff @(posedge clk) begin
        if (rst)         pair_open_q <= 1'b0;
        else if (av_req) pair_open_q <= ~av_we;
    end
endmodule

// File: rtl/avm_ret.sv
module avm_ret
    import avm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    av_rd_go,
    input  logic    hs_acc,
    input  cpoint_t ram_rdata,
    output logic    av_rvalid,
    output cpoint_t av_rdata,
    output logic    hs_valid,
    output cpoint_t hs_rdata
);
    logic hs_stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            av_rvalid  <= 1'b0;
            hs_stage_q <= 1'b0;
            hs_valid   <= 1'b0;
        end else begin
            av_rvalid  <= av_rd_go;
            hs_stage_q <= hs_acc;
            hs_valid   <= hs_stage_q;
        end
    end

    always_ff @(posedge clk) begin
        if (hs_stage_q) hs_rdata <= ram_rdata;
    end

    assign av_rdata = ram_rdata;
endmodule

// File: rtl/avm_arbiter.sv
module avm_arbiter
    import avm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  av_req,
    input  logic                  av_we,
    input  logic [ADDR_W-1:0]     av_addr,
    input  logic [POINT_W-1:0]    av_wdata,
    output logic                  av_gnt,
    output logic                  av_rvalid,
    output logic [POINT_W-1:0]    av_rdata,
    input  logic                  hs_req,
    input  logic [ADDR_W-1:0]     hs_addr,
    output logic                  hs_busy,
    output logic                  hs_valid,
    output logic [POINT_W-1:0]    hs_rdata
);
    logic              hs_acc;
    logic              av_rd_go;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    cpoint_t           ram_rdata;
    cpoint_t           av_rd_pt;
    cpoint_t           hs_rd_pt;

    avm_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .av_req   (av_req),
        .av_we    (av_we),
        .av_addr  (av_addr),
        .hs_req   (hs_req),
        .hs_addr  (hs_addr),
        .av_gnt   (av_gnt),
        .hs_busy  (hs_busy),
        .hs_acc   (hs_acc),
        .av_rd_go (av_rd_go),
        .ram_en   (ram_en),
        .ram_we   (ram_we),
        .ram_addr (ram_addr)
    );

    avm_ram #(.ADDR_W(ADDR_W), .DATA_W(POINT_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (av_wdata),
        .rdata (ram_rdata)
    );

    avm_ret u_ret (
        .clk       (clk),
        .rst       (rst),
        .av_rd_go  (av_rd_go),
        .hs_acc    (hs_acc),
        .ram_rdata (ram_rdata),
        .av_rvalid (av_rvalid),
        .av_rdata  (av_rd_pt),
        .hs_valid  (hs_valid),
        .hs_rdata  (hs_rd_pt)
    );

    assign av_rdata = av_rd_pt;
    assign hs_rdata = hs_rd_pt;
endmodule

// File: rtl/avm_arbiter_chk.sv
module avm_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic av_req,
    input logic av_we,
    input logic av_gnt,
    input logic av_rvalid,
    input logic hs_req,
    input logic hs_busy,
    input logic hs_valid
);
    a_r1_grant_follows_req: assert property (@(posedge clk) disable iff (rst)
        av_gnt == av_req);

    a_r2_collision_busy: assert property (@(posedge clk) disable iff (rst)
        (hs_req && av_req) |-> hs_busy);

    a_r3_pair_gap_busy: assert property (@(posedge clk) disable iff (rst)
        ($past(av_req && !av_we) && hs_req && !av_req) |-> hs_busy);

    a_r4_busy_needs_req: assert property (@(posedge clk) disable iff (rst)
        hs_busy |-> hs_req);

    a_r5_accept_returns: assert property (@(posedge clk) disable iff (rst)
        (hs_req && !hs_busy) |=> ##1 hs_valid);

    a_r6_refused_silent: assert property (@(posedge clk) disable iff (rst)
        (hs_req && hs_busy) |=> ##1 !hs_valid);

    a_r7_av_read_valid: assert property (@(posedge clk) disable iff (rst)
        (av_req && !av_we) |=> av_rvalid);

    a_r7_av_valid_cause: assert property (@(posedge clk) disable iff (rst)
        av_rvalid |-> $past(av_req && !av_we));
endmodule

bind avm_arbiter avm_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .av_req    (av_req),
    .av_we     (av_we),
    .av_gnt    (av_gnt),
    .av_rvalid (av_rvalid),
    .hs_req    (hs_req),
    .hs_busy   (hs_busy),
    .hs_valid  (hs_valid)
);

// File: tb/avm_arbiter_bench.sv
`timescale 1ns/1ps
module avm_arbiter_bench;
    localparam int AW = 9;
    localparam int MAXA = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          av_req = 1'b0, av_we = 1'b0, hs_req = 1'b0;
    logic [AW-1:0] av_addr = '0, hs_addr = '0;
    logic [63:0]   av_wdata = '0;
    logic          av_gnt, av_rvalid, hs_busy, hs_valid;
    logic [63:0]   av_rdata, hs_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [63:0] mref [int];
    bit          pair_m = 0;
    bit          h1_v = 0, h2_v = 0, a_v = 0;
    logic [63:0] h1_d = '0, h2_d = '0, a_d = '0;

    always #2.5 clk = ~clk;

    avm_arbiter #(.ADDR_W(AW)) u_avm_arbiter (
        .clk(clk), .rst(rst),
        .av_req(av_req), .av_we(av_we), .av_addr(av_addr), .av_wdata(av_wdata),
        .av_gnt(av_gnt), .av_rvalid(av_rvalid), .av_rdata(av_rdata),
        .hs_req(hs_req), .hs_addr(hs_addr),
        .hs_busy(hs_busy), .hs_valid(hs_valid), .hs_rdata(hs_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic logic [63:0] pt(input int re, input int im);
        return {re[31:0], im[31:0]};
    endfunction

    // one clock: drive at negedge, compare, advance model at posedge
    task automatic step(input logic ar, input logic aw, input int aa, input logic [63:0] ad,
                        input logic hr, input int ha);
        bit busy_e, acc_e, rd_e;
        av_req = ar; av_we = aw; av_addr = aa[AW-1:0]; av_wdata = ad;
        hs_req = hr; hs_addr = ha[AW-1:0];
        #1;
        busy_e = hr && (ar || pair_m);
        acc_e  = hr && !busy_e;
        rd_e   = ar && !aw;
        chk("R1 grant", {63'd0, av_gnt}, {63'd0, ar});
        if (ar && hr)            chk("R2 collision busy", {63'd0, hs_busy}, 64'd1);
        else if (pair_m && hr)   chk("R3 pair busy", {63'd0, hs_busy}, 64'd1);
        else                     chk("R4 busy only when refused", {63'd0, hs_busy}, {63'd0, busy_e});
        if (h2_v) begin
            chk("R5 host valid", {63'd0, hs_valid}, 64'd1);
            chk("R5 R8 host data", hs_rdata, h2_d);
        end else begin
            chk("R6 no host valid", {63'd0, hs_valid}, 64'd0);
        end
        chk("R7 av valid", {63'd0, av_rvalid}, {63'd0, a_v});
        if (a_v) chk("R7 R8 av data", av_rdata, a_d);
        @(posedge clk);
        h2_v = h1_v; h2_d = h1_d;
        h1_v = acc_e;
        if (acc_e) h1_d = mref.exists(ha) ? mref[ha] : 'x;
        a_v = rd_e;
        if (rd_e) a_d = mref.exists(aa) ? mref[aa] : 'x;
        if (ar && aw) mref[aa] = ad;
        if (ar) pair_m = rd_e;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset hs_valid", {63'd0, hs_valid}, 64'd0);
        chk("R9 reset av_rvalid", {63'd0, av_rvalid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // R9: host request right after reset is accepted (no pair open)
        step(0, 0, 0, '0, 1, 0);
        idle(2);
        // R8: fill addresses 0..15 and the top address
        for (int i = 0; i < 16; i++) step(1, 1, i, pt(32'h1000 + i, 32'h7000_0000 - i), 0, 0);
        step(1, 1, MAXA, pt(32'hDEAD_BEEF, 32'h0000_0001), 0, 0);
        // R5: spaced reads, then back-to-back, including ends of range
        step(0, 0, 0, '0, 1, 3); idle(3);
        step(0, 0, 0, '0, 1, 0);
        step(0, 0, 0, '0, 1, MAXA);
        step(0, 0, 0, '0, 1, 7);
        idle(3);
        // R2/R6: collision with averager write
        step(1, 1, 5, pt(32'hAAAA_5555, 32'h1234_5678), 1, 5);
        idle(3);
        step(0, 0, 0, '0, 1, 5); idle(3);
        // R3: read-modify-write with gap, host in gap and on write cycle
        step(1, 0, 9, '0, 0, 0);
        step(0, 0, 0, '0, 1, 9);
        step(0, 0, 0, '0, 1, 9);
        step(1, 1, 9, pt(32'h0BAD_F00D, 32'hCAFE_0000), 1, 2);
        step(0, 0, 0, '0, 1, 9);
        idle(3);
        // R7: averager reads back to back
        step(1, 0, MAXA, '0, 0, 0);
        step(1, 0, 0, '0, 0, 0);
        step(1, 1, 0, pt(1, 2), 0, 0);
        idle(2);
        // random mix of pairs and host reads
        for (int k = 0; k < 3000; k++) begin
            int sel;
            int a;
            sel = $urandom_range(0, 3);
            a   = $urandom_range(0, 15);
            if (sel == 0) begin
                step(1, 0, a, '0, $urandom_range(0, 1), $urandom_range(0, 15));
                if ($urandom_range(0, 1) == 1) step(0, 0, 0, '0, $urandom_range(0, 1), $urandom_range(0, 15));
                step(1, 1, a, pt($urandom, $urandom), $urandom_range(0, 1), $urandom_range(0, 15));
            end else begin
                step(0, 0, 0, '0, $urandom_range(0, 1), $urandom_range(0, 15));
            end
        end
        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule